// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-mapped management master for the IEEE 802.3 Clause 45 MDC/MDIO bus. Software writes one packed 32-bit control word to launch one frame. The word holds the frame opcode, the port address, the device address and a 16-bit payload. The block derives MDC from the system clock with an even divider. It shifts the 64-bit frame out MSB first and changes MDIO only after MDC falls. On read-type frames it releases the line from the turnaround onward and samples the PHY's 16 data bits on rising MDC edges.

Completion is handshaked through a status word that holds a busy flag, a read-valid flag and the captured data. A register access takes two frames: an address frame, then a write, read or post-read-increment frame to the same port and device. Between frames software writes a control word with both command bits clear and then polls busy again. The block enforces this: after one command is accepted, no further command starts until that zero-command write has been seen.

The command path is a two-state arm machine with states ARMED and SPENT. It moves from ARMED to SPENT on an accepted command, and from SPENT to ARMED on a control write with both command bits clear. The frame engine has four states: IDLE, HEAD, TURN and DATA. It goes from IDLE to HEAD on an accepted command. It goes from HEAD to TURN after bit 45, from TURN to DATA after bit 47, and from DATA back to IDLE after bit 63. Each of the last three moves happens on the falling MDC edge that ends the named bit.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset the status word reads zero, the control word reads zero, MDC is low and MDIO is not driven (mdio_oe low).
- R2: A write to byte address 0x0 stores the control word, and reading 0x0 returns it. Bit 31 is the write command and bit 30 the read command. When either bit is set, the engine is idle and the command path is armed, a frame starts. Busy (status bit 30) reads 1 from the cycle after the write edge for exactly 64*DIV clock cycles.
- R3: A control write with bits 31 and 30 both clear starts no frame: busy stays 0 and MDC stays low. It re-arms the command path.
- R4: A command written while busy, or written after an accepted command without an intervening zero-command write, starts no frame and does not alter the frame in flight.
- R5: The frame, sent MSB first, is 32 ones, then 00, then opcode (control bits 27:26), port address (bits 25:21), device address (bits 20:16), turnaround 10 and the 16-bit data (bits 15:0).
- R6: MDC has a period of DIV system clocks while a frame runs and is low when idle. mdio_o never changes while MDC is high.
- R7: For opcodes 3 (read) and 2 (post-read-increment), mdio_oe drops for bits 46 to 63. The 16 bits the PHY drives are sampled on rising MDC. When busy clears, read-valid (status bit 31) is 1 and status bits 15:0 hold the data.
- R8: Read-valid clears on the cycle a new command is accepted.
- R9: For opcodes 0 (address) and 1 (write), mdio_oe stays high for all 64 bits and read-valid stays 0.
- R10: Status lives at byte address 0x4 with bits 29:16 zero. Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
Busy and the cleared read-valid flag are due on the first sample after the accepting clock edge. Busy then stays high for exactly 64*DIV cycles. Read-valid and the captured data become visible on the same cycle busy falls. The bench drives on falling clock edges and samples read data 1 ns later. It counts falling edges with busy high and compares that count to 64*DIV exactly, so one cycle early or late is reported. The PHY model records mdio_o and mdio_oe on every rising MDC edge and drives reply bits after each falling MDC edge. Whole frames and drive windows are therefore compared bit for bit against the frame layout.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

    localparam int CSR_W         = 32;
    localparam int DATA_W        = 16;
    localparam int PHYAD_W       = 5;
    localparam int DEVAD_W       = 5;
    localparam int OP_W          = 2;
    localparam int PREAMBLE_BITS = 32;
    localparam int ST_BITS       = 2;
    localparam int TA_BITS       = 2;
    localparam int HEAD_BITS     = PREAMBLE_BITS + ST_BITS + OP_W + PHYAD_W + DEVAD_W;
    localparam int FRAME_BITS    = HEAD_BITS + TA_BITS + DATA_W;
    localparam int IDX_W         = $clog2(FRAME_BITS);

    // control word bit positions (software decodes these)
    localparam int CMD_WR_POS = 31;
    localparam int CMD_RD_POS = 30;
    localparam int OP_LSB     = 26;
    localparam int PHYAD_LSB  = 21;
    localparam int DEVAD_LSB  = 16;

    // status word bit positions
    localparam int STAT_VALID_POS = 31;
    localparam int STAT_BUSY_POS  = 30;

    typedef enum logic [1:0] {
        OP_ADDR    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_POSTINC = 2'd2,
        OP_READ    = 2'd3
    } mdio_op_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_HEAD,
        ENG_TURN,
        ENG_DATA
    } eng_state_e;

    typedef enum logic {
        CMD_ARMED,
        CMD_SPENT
    } arm_state_e;

    typedef struct packed {
        mdio_op_e             op;
        logic [PHYAD_W-1:0]   phyad;
        logic [DEVAD_W-1:0]   devad;
        logic [DATA_W-1:0]    data;
    } mdio_cmd_t;

    // both read-type opcodes have the upper opcode bit set
    function automatic logic op_is_read(mdio_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = DIV / 2;

    logic mdc_q;
    logic toggle;

    generate
        if (HALF <= 1) begin : g_fast
            assign toggle = run;
        end else begin : g_count
            localparam int CNT_W = $clog2(HALF);
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run || cnt_q == CNT_LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end

            assign toggle = run && (cnt_q == CNT_LAST);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_q <= 1'b0;
        end else if (!run) begin
            mdc_q <= 1'b0;
        end else if (toggle) begin
            mdc_q <= ~mdc_q;
        end
    end

    assign mdc       = mdc_q;
    assign rise_tick = toggle && !mdc_q;
    assign fall_tick = toggle && mdc_q;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_c45_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         start_cmd,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              done_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam logic [IDX_W-1:0] IDX_HEAD_LAST = IDX_W'(HEAD_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_TURN_LAST = IDX_W'(HEAD_BITS + TA_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST      = IDX_W'(FRAME_BITS - 1);

    eng_state_e              state_q, state_d;
    logic [FRAME_BITS-1:0]   tx_sr;
    logic [DATA_W-1:0]       rx_sr;
    logic [IDX_W-1:0]        idx_q;
    logic                    rd_q;
    logic                    launch;
    logic [FRAME_BITS-1:0]   frame_word;

    assign launch = start && (state_q == ENG_IDLE);

    assign frame_word = {{PREAMBLE_BITS{1'b1}}, 2'b00, start_cmd.op,
                         start_cmd.phyad, start_cmd.devad, 2'b10, start_cmd.data};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: if (launch)                               state_d = ENG_HEAD;
            ENG_HEAD: if (fall_tick && idx_q == IDX_HEAD_LAST)  state_d = ENG_TURN;
            ENG_TURN: if (fall_tick && idx_q == IDX_TURN_LAST)  state_d = ENG_DATA;
            ENG_DATA: if (fall_tick && idx_q == IDX_LAST)       state_d = ENG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b1;
        mdio_oe = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ENG_IDLE: busy = 1'b0;
            ENG_HEAD: mdio_oe = 1'b1;
            ENG_TURN: mdio_oe = !rd_q;
            ENG_DATA: begin
                mdio_oe = !rd_q;
                done    = fall_tick && (idx_q == IDX_LAST);
            end
        endcase
    end

    // datapath: shift out on falling MDC, sample in on rising MDC
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '1;
            rx_sr <= '0;
            idx_q <= '0;
            rd_q  <= 1'b0;
        end else begin
            if (launch) begin
                tx_sr <= frame_word;
                idx_q <= '0;
                rd_q  <= op_is_read(start_cmd.op);
            end else if (busy && fall_tick) begin
                tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b1};
                idx_q <= idx_q + IDX_W'(1);
            end
            if (state_q == ENG_DATA && rd_q && rise_tick) begin
                rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
            end
        end
    end

    assign mdio_o  = tx_sr[FRAME_BITS-1];
    assign done_rd = done && rd_q;
    assign rx_data = rx_sr;

endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
    import mdio_c45_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CSR_W-1:0]  bus_wdata,
    output logic [CSR_W-1:0]  bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_done_rd,
    input  logic [DATA_W-1:0] eng_rx,
    output logic              start,
    output mdio_cmd_t         start_cmd,
    output logic              armed,
    output logic              rd_valid
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(4);

    arm_state_e         arm_q, arm_d;
    logic [CSR_W-1:0]   ctrl_q;
    logic [DATA_W-1:0]  rx_q;
    logic               valid_q;
    logic               ctrl_sel;
    logic               has_cmd;
    logic [CSR_W-1:0]   status_word;

    assign ctrl_sel = bus_wr && (bus_addr == CTRL_ADDR);
    assign has_cmd  = bus_wdata[CMD_WR_POS] || bus_wdata[CMD_RD_POS];
    assign start    = ctrl_sel && has_cmd && !eng_busy && (arm_q == CMD_ARMED);

    assign start_cmd.op    = mdio_op_e'(bus_wdata[OP_LSB +: OP_W]);
    assign start_cmd.phyad = bus_wdata[PHYAD_LSB +: PHYAD_W];
    assign start_cmd.devad = bus_wdata[DEVAD_LSB +: DEVAD_W];
    assign start_cmd.data  = bus_wdata[DATA_W-1:0];

    // arm state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= CMD_ARMED;
        end else begin
            arm_q <= arm_d;
        end
    end

    // arm transitions
    always_comb begin
        arm_d = arm_q;
        unique case (arm_q)
            CMD_ARMED: if (start)                arm_d = CMD_SPENT;
            CMD_SPENT: if (ctrl_sel && !has_cmd) arm_d = CMD_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            rx_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            if (ctrl_sel) begin
                ctrl_q <= bus_wdata;
            end
            if (start) begin
                valid_q <= 1'b0;
            end else if (eng_done_rd) begin
                valid_q <= 1'b1;
            end
            if (eng_done && eng_done_rd) begin
                rx_q <= eng_rx;
            end
        end
    end

    always_comb begin
        status_word                 = '0;
        status_word[STAT_VALID_POS] = valid_q;
        status_word[STAT_BUSY_POS]  = eng_busy;
        status_word[DATA_W-1:0]     = rx_q;
    end

    always_comb begin
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata = ctrl_q;
        end else if (bus_addr == STAT_ADDR) begin
            bus_rdata = status_word;
        end else begin
            bus_rdata = '0;
        end
    end

    assign armed    = (arm_q == CMD_ARMED);
    assign rd_valid = valid_q;

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
    import mdio_c45_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DIV    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              start_w;
    mdio_cmd_t         cmd_w;
    logic              busy_w;
    logic              done_w;
    logic              done_rd_w;
    logic [DATA_W-1:0] rx_w;
    logic              armed_w;
    logic              rd_valid_w;
    logic              rise_w;
    logic              fall_w;

    mdio_csr #(
        .ADDR_W (ADDR_W)
    ) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .eng_busy    (busy_w),
        .eng_done    (done_w),
        .eng_done_rd (done_rd_w),
        .eng_rx      (rx_w),
        .start       (start_w),
        .start_cmd   (cmd_w),
        .armed       (armed_w),
        .rd_valid    (rd_valid_w)
    );

    mdio_mdc_gen #(
        .DIV (DIV)
    ) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy_w),
        .mdc       (mdc),
        .rise_tick (rise_w),
        .fall_tick (fall_w)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .start_cmd (cmd_w),
        .rise_tick (rise_w),
        .fall_tick (fall_w),
        .mdio_i    (mdio_i),
        .busy      (busy_w),
        .done      (done_w),
        .done_rd   (done_rd_w),
        .rx_data   (rx_w),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

endmodule

// File: rtl/mdio_c45_master_checker.sv
module mdio_c45_master_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        cmd_bits,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              busy,
    input logic              armed,
    input logic              rd_valid
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == '0);

    AST_CMD_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cmd_bits != 2'b00 && !busy && armed) |=> busy); // R2

    AST_ZERO_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cmd_bits == 2'b00 && !busy) |=> !busy); // R3

    AST_SPENT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !busy && !armed) |=> !busy); // R4

    AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R6

    AST_VALID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cmd_bits != 2'b00 && !busy && armed) |=> !rd_valid); // R8

endmodule

bind mdio_c45_master mdio_c45_master_checker #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .cmd_bits (bus_wdata[31:30]),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (busy_w),
    .armed    (armed_w),
    .rd_valid (rd_valid_w)
);

// File: tb/mdio_c45_master_test.sv
`timescale 1ns/1ps
module mdio_c45_master_test;
    localparam int ADDR_W = 4;
    localparam int DIV    = 8;
    localparam int FRAME_CYC = 64 * DIV;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              mdc;
    logic              mdio_o;
    logic              mdio_oe;
    logic              mdio_i = 1'b1;

    int n_checks = 0;
    int n_fails  = 0;

    // PHY model state
    logic [63:0] cap_sr = '0;
    logic [63:0] oe_sr  = '0;
    logic [15:0] phy_reply = '0;
    int          rises = 0;
    time         last_rise_t = 0;
    time         mdc_period  = 0;

    always #5 clk = ~clk;

    mdio_c45_master #(.ADDR_W(ADDR_W), .DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge mdc) begin
        cap_sr <= {cap_sr[62:0], mdio_o};
        oe_sr  <= {oe_sr[62:0], mdio_oe};
        rises  <= rises + 1;
        if (last_rise_t != 0) mdc_period <= $time - last_rise_t;
        last_rise_t <= $time;
    end

    always @(negedge mdc) begin
        if ((rises % 64) >= 48) mdio_i <= phy_reply[63 - (rises % 64)];
        else                    mdio_i <= 1'b1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input logic wr, input logic rd, input logic [1:0] op,
                                        input logic [4:0] p, input logic [4:0] d, input logic [15:0] v);
        return {wr, rd, 2'b00, op, p, d, v};
    endfunction

    function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] p,
                                              input logic [4:0] d, input logic [15:0] v);
        return {32'hFFFF_FFFF, 2'b00, op, p, d, 2'b10, v};
    endfunction

    task automatic csr_write(input logic [ADDR_W-1:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_STAT;
    endtask

    task automatic csr_read(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        logic [31:0] s;
        cyc = 0;
        while (cyc < 4 * FRAME_CYC) begin
            csr_read(A_STAT, s);
            if (!s[30]) break;
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic expect_quiet(input string req, input int cycles);
        logic [31:0] s;
        int r0 = rises;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            csr_read(A_STAT, s);
            check(req, {63'd0, s[30]}, 64'd0);
        end
        check(req, 64'(rises - r0), 64'd0);
        check(req, {63'd0, mdc}, 64'd0);
    endtask

    // one full frame with all per-frame checks; rearm issues the zero-command write
    task automatic do_frame(input logic rdcmd, input logic [1:0] op, input logic [4:0] p,
                            input logic [4:0] d, input logic [15:0] v,
                            input logic [15:0] reply, input logic rearm);
        logic [31:0] s;
        logic [63:0] ef;
        int cyc;
        logic is_rd = op[1];
        phy_reply = reply;
        csr_write(A_CTRL, ctl(!rdcmd, rdcmd, op, p, d, v));
        csr_read(A_STAT, s);
        check("R2 busy after accept", {63'd0, s[30]}, 64'd1);
        check("R8 valid cleared on accept", {63'd0, s[31]}, 64'd0);
        wait_idle(cyc);
        check("R2 busy length", 64'(cyc), 64'(FRAME_CYC));
        ef = exp_frame(op, p, d, v);
        csr_read(A_STAT, s);
        if (is_rd) begin
            check("R5 read header", {18'd0, cap_sr[63:18]}, {18'd0, ef[63:18]});
            check("R7 release window", oe_sr, {{46{1'b1}}, 18'd0});
            check("R7 read valid", {63'd0, s[31]}, 64'd1);
            check("R7 read data", {48'd0, s[15:0]}, {48'd0, reply});
        end else begin
            check("R5 frame bits", cap_sr, ef);
            check("R9 driven whole frame", oe_sr, {64{1'b1}});
            check("R9 valid stays low", {63'd0, s[31]}, 64'd0);
        end
        check("R10 status reserved bits", {50'd0, s[29:16]}, 64'd0);
        if (rearm) csr_write(A_CTRL, 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        csr_read(A_STAT, v);
        check("R1 status zero", {32'd0, v}, 64'd0);
        csr_read(A_CTRL, v);
        check("R1 control zero", {32'd0, v}, 64'd0);
        check("R1 mdc low", {63'd0, mdc}, 64'd0);
        check("R1 mdio released", {63'd0, mdio_oe}, 64'd0);
    endtask

    task automatic t_address_frame;
        do_frame(1'b0, 2'd0, 5'd5, 5'd1, 16'h1234, 16'h0000, 1'b1);
        check("R6 mdc period", 64'(mdc_period), 64'(DIV * 10));
    endtask

    task automatic t_write_frame;
        do_frame(1'b0, 2'd1, 5'h1F, 5'h1E, 16'hA5C3, 16'h0000, 1'b1);
    endtask

    task automatic t_read_frame;
        do_frame(1'b1, 2'd3, 5'd9, 5'd3, 16'h0000, 16'hBEEF, 1'b1);
    endtask

    task automatic t_postinc_frame;
        do_frame(1'b1, 2'd2, 5'd0, 5'd31, 16'h0000, 16'h8001, 1'b1);
    endtask

    task automatic t_valid_clear;
        // valid is set by the previous post-read frame; an address frame must clear it (R8)
        do_frame(1'b0, 2'd0, 5'd2, 5'd2, 16'h0F0F, 16'h0000, 1'b1);
    endtask

    task automatic t_ignore_busy;
        int cyc;
        csr_write(A_CTRL, ctl(1'b1, 1'b0, 2'd1, 5'd4, 5'd6, 16'h1111));
        repeat (100) @(negedge clk);
        csr_write(A_CTRL, 32'd0);
        csr_write(A_CTRL, ctl(1'b1, 1'b0, 2'd1, 5'd7, 5'd8, 16'h2222));
        wait_idle(cyc);
        check("R4 busy write ignored", cap_sr, exp_frame(2'd1, 5'd4, 5'd6, 16'h1111));
        expect_quiet("R4 no second frame", 3);
        // zero write during the frame re-armed the path, so the next command runs
        do_frame(1'b0, 2'd1, 5'd3, 5'd3, 16'h3C3C, 16'h0000, 1'b0);
    endtask

    task automatic t_unarmed;
        csr_write(A_CTRL, ctl(1'b1, 1'b0, 2'd0, 5'd1, 5'd1, 16'h5555));
        expect_quiet("R4 spent path ignores command", 5);
        csr_write(A_CTRL, 32'd0);
        do_frame(1'b0, 2'd0, 5'd1, 5'd1, 16'h5555, 16'h0000, 1'b1);
    endtask

    task automatic t_zero_cmd;
        logic [31:0] v;
        csr_write(A_CTRL, 32'h0C00_ABCD);
        expect_quiet("R3 zero command no frame", 5);
        csr_read(A_CTRL, v);
        check("R2 control readback", {32'd0, v}, 64'h0C00_ABCD);
    endtask

    task automatic t_other_addr;
        logic [31:0] v;
        csr_read(4'h8, v);
        check("R10 addr 8 reads zero", {32'd0, v}, 64'd0);
        csr_read(4'hC, v);
        check("R10 addr C reads zero", {32'd0, v}, 64'd0);
    endtask

    initial begin
        logic timed_out = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_address_frame();
                t_write_frame();
                t_read_frame();
                t_postinc_frame();
                t_valid_clear();
                t_ignore_busy();
                t_unarmed();
                t_zero_cmd();
                t_other_addr();
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule